// File: doc/BRIEF.md
# Bar-Code Count Packer with DMA Request

This block sits between a bar/space width counter and a host DMA engine. Each accepted 16-bit width count is paired with the next one into a 32-bit word, and the words collect in a sixteen-entry word buffer. When eight words are waiting, the block raises a DMA request, and the host drains them as a burst of eight reads through a show-ahead read port.

When the width counter reports that a frame has ended, the block stops taking counts and closes the frame. It places the end-of-data value 0xFFFF in the next free half-word after the last count. It then fills half-words with a polarity code until the frame occupies a whole number of eight-word records. The polarity code is chosen from the video level at the last count. New counts are accepted again only after every word of the closed frame has been read out.

Top module: `count_packer`

## Requirements
- R1: Two consecutive accepted counts form one word. The earlier count goes in bits 15:0 and the later count in bits 31:16.
- R2: The word buffer holds at most 16 words. `cnt_ready` is low whenever 16 words are stored, so no count or word is lost.
- R3: `dma_req` is high in every cycle in which 8 or more words are stored.
- R4: While counts are being collected and fewer than 8 words are stored, `dma_req` is low.
- R5: After `eof_pulse`, the half-word that follows the last accepted count holds 0xFFFF.
- R6: Every half-word after the 0xFFFF marker in the same frame holds 0xFFFA if `eof_level` was 1 at the end-of-frame pulse, or 0xFFF5 if it was 0.
- R7: Padding stops at the first eight-word boundary at or after the word that holds the marker. A frame of N counts therefore produces 8·ceil((N+1)/16) words, and `dma_req` falls once they have all been read.
- R8: From the cycle after `eof_pulse` until the buffer has been fully drained, `cnt_ready` is low. It returns high the cycle after the buffer becomes empty.
- R9: `rd_data` always shows the oldest stored word, and `rd_en` removes it. `rd_en` on an empty buffer has no effect.
- R10: After reset the buffer is empty, `dma_req` is low and `cnt_ready` is high.
- R11: `cnt_ready` is low during a cycle with `eof_pulse` high. An `eof_pulse` that arrives while a frame is being closed or drained is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_valid | input | 1 | A width count is offered |
| cnt_data | input | 16 | The width count |
| cnt_ready | output | 1 | The count is taken in this cycle if `cnt_valid` is high |
| eof_pulse | input | 1 | One-cycle end-of-frame strobe |
| eof_level | input | 1 | Video level at the last count, sampled with `eof_pulse` |
| dma_req | output | 1 | A burst of eight words may be read |
| rd_en | input | 1 | Removes the word shown on `rd_data` |
| rd_data | output | 32 | Oldest stored word |

## Verification
The properties assume that the host reads only while `dma_req` is high and takes no more than eight words per request. They also assume that `eof_pulse` is a single-cycle strobe. The bench reads in bursts of exactly eight words, and only after it has sampled `dma_req` high, so a closed frame is always removed in whole records. It never offers a count and an end-of-frame strobe in the same cycle. It drives a second strobe during draining on purpose, to show that the block ignores it. The frame lengths swept include both a completely filled buffer with no reads and long frames read while counts are still arriving.

// File: rtl/cp_pkg.sv
package cp_pkg;

  localparam int CNT_W = 16;

  localparam logic [CNT_W-1:0] END_MARK = 16'hFFFF;
  localparam logic [CNT_W-1:0] PAD_HI   = 16'hFFFA;
  localparam logic [CNT_W-1:0] PAD_LO   = 16'hFFF5;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_TERM    = 2'd1,
    ST_DRAIN   = 2'd2
  } cp_state_e;

  // polarity filler chosen from the last video level
  function automatic logic [CNT_W-1:0] pad_code(input logic lvl);
    return lvl ? PAD_HI : PAD_LO;
  endfunction

  // earlier half in the low bits, later half in the high bits
  function automatic logic [2*CNT_W-1:0] pack_pair(input logic [CNT_W-1:0] first,
                                                   input logic [CNT_W-1:0] second);
    return {second, first};
  endfunction

  // a request is due at half capacity, or while a closed frame remains
  function automatic logic req_due(input logic at_half, input logic draining,
                                   input logic has_data);
    return at_half | (draining & has_data);
  endfunction

endpackage

// File: rtl/cp_half_packer.sv
module cp_half_packer
  import cp_pkg::*;
#(
  parameter int BURST = 8,
  localparam int PW = (BURST > 1) ? $clog2(BURST) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hw_valid,
  input  logic [CNT_W-1:0]   hw_data,
  output logic               half_pend,
  output logic               rec_last,
  output logic               word_push,
  output logic [2*CNT_W-1:0] word_data
);

  localparam logic [PW-1:0] LAST_POS = PW'(BURST - 1);

  logic [CNT_W-1:0] low_q;
  logic [PW-1:0]    wpos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q     <= '0;
      half_pend <= 1'b0;
      wpos_q    <= '0;
    end else if (hw_valid) begin
      if (!half_pend) begin
        low_q     <= hw_data;
        half_pend <= 1'b1;
      end else begin
        half_pend <= 1'b0;
        wpos_q    <= (wpos_q == LAST_POS) ? '0 : wpos_q + 1'b1;
      end
    end
  end

  assign rec_last  = (wpos_q == LAST_POS);
  assign word_push = hw_valid & half_pend;
  assign word_data = pack_pair(low_q, hw_data);

endmodule

// File: rtl/cp_word_fifo.sv
module cp_word_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [LW-1:0]    level,
  output logic             full,
  output logic             empty
);

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [LW-1:0] DEPTH_L  = LW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (level == DEPTH_L);
  assign empty   = (level == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/cp_frame_ctrl.sv
module cp_frame_ctrl
  import cp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_valid,
  input  logic [CNT_W-1:0] cnt_data,
  input  logic             eof_pulse,
  input  logic             eof_level,
  input  logic             buf_full,
  input  logic             buf_empty,
  input  logic             half_pend,
  input  logic             rec_last,
  output logic             cnt_ready,
  output logic             hw_valid,
  output logic [CNT_W-1:0] hw_data,
  output cp_state_e        state
);

  logic             mark_sent;
  logic [CNT_W-1:0] pad_q;
  logic             term_push;
  logic             rec_closes;

  // a half-word in termination completes the record when it fills the last word slot
  assign term_push  = (state == ST_TERM) & ~buf_full;
  assign rec_closes = term_push & half_pend & rec_last;

  always_comb begin
    cnt_ready = 1'b0;
    hw_valid  = 1'b0;
    hw_data   = cnt_data;
    case (state)
      ST_COLLECT: begin
        cnt_ready = ~buf_full & ~eof_pulse;
        hw_valid  = cnt_valid & cnt_ready;
      end
      ST_TERM: begin
        hw_valid = term_push;
        hw_data  = mark_sent ? pad_q : END_MARK;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_COLLECT;
      mark_sent <= 1'b0;
      pad_q     <= PAD_LO;
    end else begin
      case (state)
        ST_COLLECT: if (eof_pulse) begin
          state     <= ST_TERM;
          mark_sent <= 1'b0;
          pad_q     <= pad_code(eof_level);
        end
        ST_TERM: begin
          if (term_push)  mark_sent <= 1'b1;
          if (rec_closes) state     <= ST_DRAIN;
        end
        ST_DRAIN: if (buf_empty) state <= ST_COLLECT;
        default: state <= ST_COLLECT;
      endcase
    end
  end

endmodule

// File: rtl/count_packer.sv
module count_packer
  import cp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int BURST = 8,
  localparam int WORD_W = 2 * CNT_W,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_valid,
  input  logic [15:0]       cnt_data,
  output logic              cnt_ready,
  input  logic              eof_pulse,
  input  logic              eof_level,
  output logic              dma_req,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data
);

  localparam logic [LW-1:0] BURST_L = LW'(BURST);

  logic              hw_valid;
  logic [CNT_W-1:0]  hw_data;
  logic              half_pend;
  logic              rec_last;
  logic              word_push;
  logic [WORD_W-1:0] word_data;
  logic [LW-1:0]     level;
  logic              buf_full, buf_empty;
  cp_state_e         state;

  cp_frame_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_valid (cnt_valid),
    .cnt_data  (cnt_data),
    .eof_pulse (eof_pulse),
    .eof_level (eof_level),
    .buf_full  (buf_full),
    .buf_empty (buf_empty),
    .half_pend (half_pend),
    .rec_last  (rec_last),
    .cnt_ready (cnt_ready),
    .hw_valid  (hw_valid),
    .hw_data   (hw_data),
    .state     (state)
  );

  cp_half_packer #(.BURST(BURST)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_valid  (hw_valid),
    .hw_data   (hw_data),
    .half_pend (half_pend),
    .rec_last  (rec_last),
    .word_push (word_push),
    .word_data (word_data)
  );

  cp_word_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (word_push),
    .wdata (word_data),
    .pop   (rd_en),
    .rdata (rd_data),
    .level (level),
    .full  (buf_full),
    .empty (buf_empty)
  );

  assign dma_req = req_due(level >= BURST_L, state == ST_DRAIN, ~buf_empty);

endmodule

// File: rtl/cp_checker.sv
module cp_checker
  import cp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int BURST = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_ready,
  input logic          eof_pulse,
  input logic          dma_req,
  input logic          word_push,
  input logic [LW-1:0] level,
  input logic          buf_full,
  input logic          buf_empty,
  input cp_state_e     state
);

  localparam logic [LW-1:0] BURST_L = LW'(BURST);
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  // R2
  full_blocks_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !cnt_ready);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_push |-> !buf_full);

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= DEPTH_L);

  // R3
  req_at_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= BURST_L) |-> dma_req);

  // R4
  no_early_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COLLECT && level < BURST_L) |-> !dma_req);

  // R5
  eof_starts_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COLLECT && eof_pulse) |=> (state == ST_TERM));

  // R8
  closed_frame_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_COLLECT) |-> !cnt_ready);

  // R8
  drain_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN && buf_empty) |=> (state == ST_COLLECT && cnt_ready == !buf_full));

  // R11
  eof_blocks_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_pulse |-> !cnt_ready);

endmodule

bind count_packer cp_checker #(.DEPTH(DEPTH), .BURST(BURST)) u_cp_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_ready (cnt_ready),
  .eof_pulse (eof_pulse),
  .dma_req   (dma_req),
  .word_push (word_push),
  .level     (level),
  .buf_full  (buf_full),
  .buf_empty (buf_empty),
  .state     (state)
);

// File: tb/test_count_packer.sv
module test_count_packer;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_valid = 1'b0;
  logic [15:0] cnt_data = '0;
  logic        cnt_ready;
  logic        eof_pulse = 1'b0;
  logic        eof_level = 1'b0;
  logic        dma_req;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit counts_done;
  bit all_done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  count_packer i_count_packer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_valid (cnt_valid),
    .cnt_data  (cnt_data),
    .cnt_ready (cnt_ready),
    .eof_pulse (eof_pulse),
    .eof_level (eof_level),
    .dma_req   (dma_req),
    .rd_en     (rd_en),
    .rd_data   (rd_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] count_val(input int n, input int h);
    return 16'((n << 9) ^ (h * 37) ^ 16'h1234) & 16'h7FFF;
  endfunction

  // expected half-word h of a frame of n counts closed with level lvl
  function automatic logic [15:0] exp_half(input int n, input int h, input bit lvl);
    if (h < n)  return count_val(n, h);
    if (h == n) return 16'hFFFF;
    return lvl ? 16'hFFFA : 16'hFFF5;
  endfunction

  function automatic int exp_words(input int n);
    return ((n + 1 + 15) / 16) * 8;
  endfunction

  task automatic producer(input int n, input bit lvl, input bit hold);
    for (int i = 0; i < n; i++) begin
      bit taken = 1'b0;
      while (!taken) begin
        @(negedge clk);
        cnt_valid = 1'b1;
        cnt_data  = count_val(n, i);
        #1 taken = cnt_ready;
        @(posedge clk);
      end
    end
    @(negedge clk);
    cnt_valid = 1'b0;
    if (hold) begin
      if ((n / 2) < 8) check(dma_req == 1'b0, "R4", 32'(dma_req), 32'd0);
      else             check(dma_req == 1'b1, "R3", 32'(dma_req), 32'd1);
      if (n == 32)     check(cnt_ready == 1'b0, "R2", 32'(cnt_ready), 32'd0);
    end
    eof_pulse = 1'b1;
    eof_level = lvl;
    #1 check(cnt_ready == 1'b0, "R11", 32'(cnt_ready), 32'd0);
    @(negedge clk);
    eof_pulse = 1'b0;
    check(cnt_ready == 1'b0, "R8", 32'(cnt_ready), 32'd0);
    counts_done = 1'b1;
    // a stray end-of-frame while the frame is closing must change nothing (R11)
    repeat (3) @(negedge clk);
    eof_pulse = 1'b1;
    eof_level = ~lvl;
    @(negedge clk);
    eof_pulse = 1'b0;
  endtask

  task automatic consumer(input int n, input bit lvl, input bit hold);
    int got = 0;
    int total = exp_words(n);
    if (hold) wait (counts_done);
    while (got < total) begin
      @(negedge clk);
      if (dma_req) begin
        for (int k = 0; k < 8; k++) begin
          int h0 = 2 * (got + k);
          logic [31:0] exp = {exp_half(n, h0 + 1, lvl), exp_half(n, h0, lvl)};
          string tag = (h0 + 1 < n) ? "R1" : ((h0 <= n) ? "R5" : "R6");
          check(rd_data == exp, tag, rd_data, exp);
          rd_en = 1'b1;
          @(negedge clk);
        end
        rd_en = 1'b0;
        got += 8;
      end
    end
    check(dma_req == 1'b0, "R7", 32'(dma_req), 32'd0);
    @(negedge clk);
    check(cnt_ready == 1'b1, "R8", 32'(cnt_ready), 32'd1);
  endtask

  task automatic run_frame(input int n, input bit lvl, input bit hold);
    // read on an empty buffer first: must not disturb anything (R9)
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(dma_req == 1'b0, "R9", 32'(dma_req), 32'd0);
    counts_done = 1'b0;
    fork
      producer(n, lvl, hold);
      consumer(n, lvl, hold);
    join
    repeat (6) @(negedge clk);
    check(dma_req == 1'b0, "R7", 32'(dma_req), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dma_req == 1'b0, "R10", 32'(dma_req), 32'd0);
    check(cnt_ready == 1'b1, "R10", 32'(cnt_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(cnt_ready == 1'b1, "R10", 32'(cnt_ready), 32'd1);
    // buffer filled with no reads, every length up to the full 16 words
    for (int n = 0; n <= 32; n++) begin
      run_frame(n, 1'b1, 1'b1);
      run_frame(n, 1'b0, 1'b1);
    end
    // longer frames read while counts keep arriving
    for (int n = 33; n <= 72; n++) begin
      run_frame(n, n[0], 1'b0);
    end
    all_done = 1'b1;
  end

  initial begin
    fork
      wait (all_done);
      begin
        repeat (WD_CYCLES) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule